// File: doc/BRIEF.md
# Infrared Remote Frame Transmitter

This block turns one address word and one command word into the pulse-distance waveform of a single infrared remote-control frame on one output line. A frame opens with a long active burst and a shorter silent gap, carries thirty-two data symbols and closes with a short active trailer. Each symbol is a fixed active pulse followed by a silent gap, and the length of that gap gives the bit value. Data is accepted through a valid/ready handshake. The frame timing is counted in ticks, and a tick is the system clock divided by an 8-bit divider taken from a configuration input.

When the carrier is enabled, the active parts of the waveform are chopped by a square wave with a 50 % duty cycle. When it is disabled, the active parts are a plain high level. For short addresses, a compact mode sends an 8-bit address followed by its bitwise inverse. A stop input aborts a frame at once. A done pulse with an aborted flag reports how each frame ended.

Top module: `nec_frame_tx`

## Requirements
- R1: After reset, line_out, busy and done are 0, and in_ready is 1 whenever cfg_div is nonzero.
- R2: A frame is accepted on a clock edge where in_valid and in_ready are both 1. From that edge until the edge that ends the trailer, busy is 1 and in_ready is 0. in_valid asserted while busy has no effect on the waveform.
- R3: A frame starts with HDR_ON ticks of active level, followed by HDR_OFF ticks of idle level.
- R4: A data symbol is SYM_ON ticks active, then ONE_OFF ticks idle for bit value 1, or ZERO_OFF ticks idle for bit value 0.
- R5: Symbol order is address-field bit 0 up to bit 15, then in_cmd bit 0 up to bit 15.
- R6: When addr8_mode is 1 at acceptance, the address field is {~in_addr[7:0], in_addr[7:0]}, and in_addr[15:8] is ignored.
- R7: The frame ends with TRL_ON ticks active. On the following clock line_out is 0, busy is 0, and done pulses for exactly one cycle with aborted 0.
- R8: One tick lasts cfg_div clock cycles, using the value sampled at acceptance. Every segment of N ticks therefore lasts N*cfg_div clocks.
- R9: While cfg_div is 0, cfg_err is 1, in_ready is 0, and no frame starts.
- R10: With carrier_en set to 1 at acceptance, line_out during an active segment is 1 only in frame cycles n for which (n / CAR_HALF) is even, where n = 0 is the first cycle after acceptance. With carrier_en set to 0, active segments drive a steady 1. Idle segments always drive 0.
- R11: If stop is 1 on a clock edge while busy, then after that edge line_out is 0 and busy is 0, and done and aborted are both 1 for one cycle.
- R12: stop while idle has no effect: done stays 0 and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Frame request present |
| in_ready | output | 1 | Block can accept a frame |
| in_addr | input | 16 | Address word, or an 8-bit address in the low byte |
| in_cmd | input | 16 | Command word |
| addr8_mode | input | 1 | Send the low address byte followed by its inverse |
| carrier_en | input | 1 | Chop active segments with the carrier |
| cfg_div | input | 8 | Clock cycles per tick (0 is invalid) |
| stop | input | 1 | Abort the frame in progress |
| line_out | output | 1 | Modulated output line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| aborted | output | 1 | Valid with done: the frame was stopped |
| cfg_err | output | 1 | Divider value is invalid |

## Verification
The bench shrinks the timing to HDR_ON=8, HDR_OFF=4, SYM_ON=2, ONE_OFF=5, ZERO_OFF=2, TRL_ON=3 and CAR_HALF=3, with DUR_W=8. A whole frame then fits in a few hundred clocks, and every cycle of it can be compared against a model. Running frames at cfg_div values of 1, 2 and 3 shows that every segment scales with the divider. The short carrier half-period places several carrier edges inside each active pulse, so the carrier phase can be checked against the frame's cycle count.

// File: rtl/nec_frame_tx.sv
module nec_frame_tx #(
  parameter int DIV_W    = 8,
  parameter int FIELD_W  = 16,
  parameter int DUR_W    = 12,
  parameter int HDR_ON   = 900,
  parameter int HDR_OFF  = 450,
  parameter int SYM_ON   = 56,
  parameter int ONE_OFF  = 169,
  parameter int ZERO_OFF = 56,
  parameter int TRL_ON   = 56,
  parameter int CAR_HALF = 1645
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FIELD_W-1:0] in_addr,
  input  logic [FIELD_W-1:0] in_cmd,
  input  logic               addr8_mode,
  input  logic               carrier_en,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               stop,
  output logic               line_out,
  output logic               busy,
  output logic               done,
  output logic               aborted,
  output logic               cfg_err
);
  localparam int NBITS = 2 * FIELD_W;
  localparam int IW    = $clog2(NBITS);
  localparam int HALF  = FIELD_W / 2;
  localparam int CARW  = $clog2(CAR_HALF + 1);

  typedef enum logic [2:0] {S_IDLE, S_HON, S_HOFF, S_BON, S_BOFF, S_TRL} state_t;

  state_t             state;
  logic [DIV_W-1:0]   pre, div_q;
  logic [DUR_W-1:0]   dur;
  logic [IW-1:0]      idx;
  logic [NBITS-1:0]   shreg;
  logic               car_on_q, car;
  logic [CARW-1:0]    car_cnt;

  wire                tick    = (pre == '0);
  wire                accept  = in_valid && in_ready;
  wire [FIELD_W-1:0]  addr_f  = addr8_mode ? {~in_addr[HALF-1:0], in_addr[HALF-1:0]} : in_addr;
  wire [DUR_W-1:0]    off_len = shreg[0] ? DUR_W'(ONE_OFF - 1) : DUR_W'(ZERO_OFF - 1);
  wire                act     = (state == S_HON) || (state == S_BON) || (state == S_TRL);

  assign busy     = (state != S_IDLE);
  assign cfg_err  = (cfg_div == '0);
  assign in_ready = !busy && !cfg_err;
  assign line_out = act && (!car_on_q || car);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pre      <= '0;
      div_q    <= '0;
      dur      <= '0;
      idx      <= '0;
      shreg    <= '0;
      car_on_q <= 1'b0;
      car      <= 1'b0;
      car_cnt  <= '0;
      done     <= 1'b0;
      aborted  <= 1'b0;
    end else begin
      done    <= 1'b0;
      aborted <= 1'b0;
      if (state == S_IDLE) begin
        if (accept) begin
          state    <= S_HON;
          dur      <= DUR_W'(HDR_ON - 1);
          pre      <= cfg_div - 1'b1;
          div_q    <= cfg_div;
          shreg    <= {in_cmd, addr_f};
          idx      <= '0;
          car      <= 1'b1;
          car_cnt  <= '0;
          car_on_q <= carrier_en;
        end
      end else if (stop) begin
        state   <= S_IDLE;
        done    <= 1'b1;
        aborted <= 1'b1;
      end else begin
        if (car_cnt == CARW'(CAR_HALF - 1)) begin
          car_cnt <= '0;
          car     <= ~car;
        end else begin
          car_cnt <= car_cnt + 1'b1;
        end
        pre <= tick ? div_q - 1'b1 : pre - 1'b1;
        if (tick) begin
          if (dur != '0) begin
            dur <= dur - 1'b1;
          end else begin
            case (state)
              S_HON: begin
                state <= S_HOFF;
                dur   <= DUR_W'(HDR_OFF - 1);
              end
              S_HOFF: begin
                state <= S_BON;
                dur   <= DUR_W'(SYM_ON - 1);
              end
              S_BON: begin
                state <= S_BOFF;
                dur   <= off_len;
              end
              S_BOFF: begin
                if (idx == IW'(NBITS - 1)) begin
                  state <= S_TRL;
                  dur   <= DUR_W'(TRL_ON - 1);
                end else begin
                  state <= S_BON;
                  dur   <= DUR_W'(SYM_ON - 1);
                  idx   <= idx + 1'b1;
                  shreg <= shreg >> 1;
                end
              end
              S_TRL: begin
                state <= S_IDLE;
                done  <= 1'b1;
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/nec_frame_tx_chk.sv
module nec_frame_tx_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             stop,
  input logic [DIV_W-1:0] cfg_div,
  input logic             line_out,
  input logic             busy,
  input logic             done,
  input logic             aborted
);
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !line_out);
  p_no_ready_busy_r2: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !in_ready);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_abort_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n) aborted |-> done);
  p_div_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_div == '0 && !busy) |=> !busy);
  p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop) |=> (!busy && done && aborted && !line_out));
  p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop && !in_valid) |=> (!done && !busy));
endmodule

bind nec_frame_tx nec_frame_tx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .stop(stop), .cfg_div(cfg_div), .line_out(line_out), .busy(busy),
  .done(done), .aborted(aborted)
);

// File: tb/test_nec_frame_tx.sv
module test_nec_frame_tx;
  localparam int HDR_ON = 8, HDR_OFF = 4, SYM_ON = 2, ONE_OFF = 5, ZERO_OFF = 2, TRL_ON = 3;
  localparam int CAR_HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, addr8_mode = 1'b0, carrier_en = 1'b0, stop = 1'b0;
  logic [15:0] in_addr = '0, in_cmd = '0;
  logic [7:0] cfg_div = 8'd1;
  logic in_ready, line_out, busy, done, aborted, cfg_err;

  always #4 clk = ~clk;

  nec_frame_tx #(
    .DIV_W(8), .FIELD_W(16), .DUR_W(8), .HDR_ON(HDR_ON), .HDR_OFF(HDR_OFF),
    .SYM_ON(SYM_ON), .ONE_OFF(ONE_OFF), .ZERO_OFF(ZERO_OFF), .TRL_ON(TRL_ON),
    .CAR_HALF(CAR_HALF)
  ) i_nec_frame_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_cmd(in_cmd), .addr8_mode(addr8_mode),
    .carrier_en(carrier_en), .cfg_div(cfg_div), .stop(stop),
    .line_out(line_out), .busy(busy), .done(done), .aborted(aborted), .cfg_err(cfg_err)
  );

  bit    exp_q[$];
  int    n_cmp = 0, n_bad = 0, fc = 0, cyc = 0;
  string cur_req = "R3";

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: compare every busy cycle against the expected waveform
  always @(negedge clk) begin
    if (rst_n && busy) begin
      if (exp_q.size() > 0) begin
        bit e;
        e = exp_q.pop_front();
        check(line_out === e && in_ready === 1'b0, cur_req,
              $sformatf("line/ready at frame cycle %0d", cyc), {in_ready, line_out}, {1'b0, e});
      end else begin
        check(1'b0, "R7", "busy beyond expected frame end", 1, 0);
      end
      cyc++;
    end
  end

  task automatic push_seg(bit act, int ticks, int dv, bit ce);
    for (int k = 0; k < ticks * dv; k++) begin
      bit c;
      c = ((fc / CAR_HALF) % 2) == 0;
      exp_q.push_back(act && (!ce || c));
      fc++;
    end
  endtask

  task automatic build(logic [15:0] a, logic [15:0] c, bit a8, int dv, bit ce);
    logic [15:0] f;
    f = a8 ? {~a[7:0], a[7:0]} : a;
    fc = 0;
    exp_q.delete();
    push_seg(1'b1, HDR_ON, dv, ce);
    push_seg(1'b0, HDR_OFF, dv, ce);
    for (int i = 0; i < 32; i++) begin
      bit b;
      b = (i < 16) ? f[i] : c[i-16];
      push_seg(1'b1, SYM_ON, dv, ce);
      push_seg(1'b0, b ? ONE_OFF : ZERO_OFF, dv, ce);
    end
    push_seg(1'b1, TRL_ON, dv, ce);
  endtask

  task automatic start(logic [15:0] a, logic [15:0] c, bit a8, int dv, bit ce);
    @(negedge clk);
    in_addr = a; in_cmd = c; addr8_mode = a8; cfg_div = 8'(dv); carrier_en = ce;
    cyc = 0;
    in_valid = 1'b1;
    @(posedge clk);
  endtask

  task automatic run_frame(logic [15:0] a, logic [15:0] c, bit a8, int dv, bit ce,
                           bit poke, string req);
    cur_req = req;
    build(a, c, a8, dv, ce);
    start(a, c, a8, dv, ce);
    @(negedge clk);
    in_valid = 1'b0;
    if (poke) begin
      // R2: a second request during the frame must be ignored
      in_addr = 16'hFFFF; in_cmd = 16'hFFFF; cfg_div = 8'd7; carrier_en = ~ce;
      in_valid = 1'b1;
      repeat (6) @(negedge clk);
      check(in_ready === 1'b0, "R2", "in_ready while busy", in_ready, 0);
      in_valid = 1'b0;
      cfg_div = 8'(dv);
    end
    do @(negedge clk); while (!done);
    check(exp_q.size() == 0, "R7", "frame ended early, cycles left", exp_q.size(), 0);
    check(aborted === 1'b0 && line_out === 1'b0 && busy === 1'b0, "R7",
          "end state {aborted,line,busy}", {aborted, line_out, busy}, 0);
    check(in_ready === 1'b1, "R2", "in_ready after frame", in_ready, 1);
    @(negedge clk);
    check(done === 1'b0, "R7", "done pulse width", done, 0);
    exp_q.delete();
  endtask

  task automatic run_stop(logic [15:0] a, logic [15:0] c, int dv, bit ce, int s);
    cur_req = "R11";
    build(a, c, 1'b0, dv, ce);
    while (exp_q.size() > s) void'(exp_q.pop_back());
    start(a, c, 1'b0, dv, ce);
    repeat (s) @(negedge clk);
    in_valid = 1'b0;
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(done === 1'b1 && aborted === 1'b1, "R11", "done/aborted after stop",
          {done, aborted}, 3);
    check(busy === 1'b0 && line_out === 1'b0, "R11", "busy/line after stop",
          {busy, line_out}, 0);
    check(exp_q.size() == 0, "R11", "cycles left before stop", exp_q.size(), 0);
    @(negedge clk);
    check(done === 1'b0 && aborted === 1'b0, "R11", "abort pulse width", {done, aborted}, 0);
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1: reset state
    check(line_out === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "reset outputs",
          {line_out, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1 && cfg_err === 1'b0, "R1", "ready after reset", in_ready, 1);

    run_frame(16'h1234, 16'h00FF, 1'b0, 1, 1'b0, 1'b0, "R3/R4/R5 plain div1");
    run_frame(16'hFFFF, 16'h0000, 1'b0, 2, 1'b0, 1'b1, "R2/R8 div2 poke");
    run_frame(16'hAB5A, 16'h8001, 1'b1, 3, 1'b0, 1'b0, "R6/R8 addr8 div3");
    run_frame(16'h0011, 16'hC3A5, 1'b0, 1, 1'b1, 1'b0, "R10 carrier div1");
    run_frame(16'h9E00, 16'h7FFE, 1'b1, 2, 1'b1, 1'b0, "R6/R10 carrier addr8 div2");

    // R9: zero divider blocks acceptance
    @(negedge clk);
    cfg_div = 8'd0;
    in_valid = 1'b1;
    @(negedge clk);
    check(cfg_err === 1'b1 && in_ready === 1'b0, "R9", "cfg_err/in_ready at div 0",
          {cfg_err, in_ready}, 2);
    repeat (8) @(negedge clk);
    check(busy === 1'b0 && line_out === 1'b0, "R9", "no frame with div 0", busy, 0);
    in_valid = 1'b0;
    cfg_div = 8'd1;

    // R12: stop while idle
    stop = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R12", "idle stop effect", {done, busy}, 0);
    end
    stop = 1'b0;

    run_stop(16'h5555, 16'h1111, 2, 1'b0, 30);
    run_stop(16'h0F0F, 16'h2222, 1, 1'b1, 5);
    run_frame(16'h0001, 16'h8000, 1'b0, 1, 1'b0, 1'b0, "R5 edge bits after abort");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule